// File: doc/BRIEF.md
# Reset and Oscillator Stabilization Sequencer

This block gathers every reset request of a small microcontroller core and turns them into one internal reset and one CPU run-enable. The requests come from a power-on detector, an external reset pin (active low, asynchronous), a watchdog timeout and an illegal-address detector. There is no low-voltage reset request. Once every request has gone away, the block keeps the core in reset while a counter waits for the oscillator to settle. The run-enable is granted only when that count completes.

The same counter covers wake-up from stop mode. While stopped, the run-enable is withheld and the counter sits idle. A wake event starts the count from zero, and the CPU clock enable returns only when the count has run out. An option input selects a long delay of 4064 bus cycles or a short delay of 128 bus cycles. A two-bit output records which request caused the most recent reset.

All pins are plain control and status levels. No data flows through the block, so it has no valid/ready interface and no back-pressure.

Top module: `rst_seq`

## Requirements
- R1: While `por_req` is high, `core_rst` is 1, `run_en` is 0 and `rst_cause` is 2'b00 (power-on), without waiting for a clock edge. Power-on outranks every other request.
- R2: `ext_rst_n` passes through a two-flop synchronizer. A low that covers two or more consecutive rising edges causes a reset, with `core_rst` high no later than the fourth edge after the low begins and `rst_cause` = 2'b01. A low that covers only one edge is ignored: outputs and `rst_cause` stay unchanged.
- R3: `wdog_to` or `bad_addr` sampled high at a rising edge sets `core_rst`=1 and `run_en`=0 after that edge, with `rst_cause` = 2'b10 for watchdog or 2'b11 for illegal address.
- R4: When requests arrive at the same edge, the recorded cause follows the priority pin > watchdog > illegal address.
- R5: While any request stays active, the delay counter is held at zero. The count starts only after the last edge at which a request is sampled.
- R6: With `short_delay`=0, `run_en` rises (and `core_rst` falls) at the 4065th rising edge after the last edge that samples a request. After `por_req` falls, the same edge is the 4065th rising edge.
- R7: With `short_delay`=1, the same release happens at the 129th rising edge.
- R8: `stop_req` sampled high while running drops `run_en` after that edge, with `core_rst` staying 0. The block then stays stopped until a wake event.
- R9: `wake` sampled high while stopped restarts the counter from zero. `run_en` rises at the Nth edge after that edge (N = 4064 or 128), and `core_rst` stays 0 throughout.
- R10: A reset request during stop or during the wake-up count takes the full reset path of R3, R6 and R7.
- R11: `core_rst` and `run_en` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| por_req | input | 1 | Power-on detector output, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_to | input | 1 | Watchdog timeout request, synchronous |
| bad_addr | input | 1 | Illegal address access request, synchronous |
| short_delay | input | 1 | Option bit: 1 selects the 128-cycle delay |
| stop_req | input | 1 | Request to enter stop mode |
| wake | input | 1 | Wake-up event from stop mode |
| core_rst | output | 1 | Internal reset to the core, active high |
| run_en | output | 1 | CPU clock enable |
| rst_cause | output | 2 | Cause of last reset: 00 power-on, 01 pin, 10 watchdog, 11 illegal address |

## Verification
The bench measures the release edge exactly after power-on, after the external pin, after a watchdog pulse and after wake-up, with both delay settings. A counter that was off by one, or a reset path that lacked the hold cycle, would move `run_en` by one edge and be caught. A one-cycle glitch on the pin must leave the part running with its old cause; a filter that was too eager would reset the part. A watchdog request held for 200 cycles, longer than the short delay, catches a counter that runs while a request is still present. Simultaneous requests and a request that arrives during stop check that the cause priority is right and that wake-up never skips the reset path.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_HOLD     = 3'd0,
    SEQ_RST_CNT  = 3'd1,
    SEQ_RUN      = 3'd2,
    SEQ_STOP     = 3'd3,
    SEQ_WAKE_CNT = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    CAUSE_POR  = 2'b00,
    CAUSE_PIN  = 2'b01,
    CAUSE_WDOG = 2'b10,
    CAUSE_ADDR = 2'b11
  } rst_cause_e;
endpackage

// File: rtl/rst_pin_filter.sv
`timescale 1ns/1ps
// Synchronizes the active-low pin and qualifies a low lasting QUAL_CYC edges.
module rst_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYC    = 2
) (
  input  logic clk,
  input  logic por_req,
  input  logic pin_n,
  output logic pin_rst
);
  localparam int TOTAL = SYNC_STAGES + QUAL_CYC - 1;

  logic [TOTAL-1:0] chain;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) chain <= '1;
    else         chain <= {chain[TOTAL-2:0], pin_n};
  end

  // Qualified when every post-synchronizer tap is low.
  assign pin_rst = ~|chain[TOTAL-1:SYNC_STAGES-1];
endmodule

// File: rtl/rst_stab_counter.sv
`timescale 1ns/1ps
module rst_stab_counter #(
  parameter int LONG_CYC  = 4064,
  parameter int SHORT_CYC = 128
) (
  input  logic clk,
  input  logic por_req,
  input  logic clear,
  input  logic en,
  input  logic short_sel,
  output logic done
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)    cnt <= '0;
    else if (clear) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end

  assign done = en && (cnt == (short_sel ? SHORT_LAST : LONG_LAST));
endmodule

// File: rtl/rst_cause_log.sv
`timescale 1ns/1ps
module rst_cause_log
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       por_req,
  input  logic       src_pin,
  input  logic       src_wdog,
  input  logic       src_addr,
  output rst_cause_e cause
);
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)       cause <= CAUSE_POR;
    else if (src_pin)  cause <= CAUSE_PIN;
    else if (src_wdog) cause <= CAUSE_WDOG;
    else if (src_addr) cause <= CAUSE_ADDR;
  end
endmodule

// File: rtl/rst_seq.sv
`timescale 1ns/1ps
module rst_seq
  import rst_seq_pkg::*;
#(
  parameter int LONG_CYC    = 4064,
  parameter int SHORT_CYC   = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       ext_rst_n,
  input  logic       wdog_to,
  input  logic       bad_addr,
  input  logic       short_delay,
  input  logic       stop_req,
  input  logic       wake,
  output logic       core_rst,
  output logic       run_en,
  output logic [1:0] rst_cause
);
  seq_state_e state, state_nx;
  logic       src_pin, any_src, counting, cnt_done;
  rst_cause_e cause;

  rst_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CYC(2)) u_pin (
    .clk(clk), .por_req(por_req), .pin_n(ext_rst_n), .pin_rst(src_pin)
  );

  assign any_src  = src_pin | wdog_to | bad_addr;
  assign counting = (state == SEQ_RST_CNT) || (state == SEQ_WAKE_CNT);

  rst_stab_counter #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_cnt (
    .clk(clk), .por_req(por_req),
    .clear(any_src || !counting), .en(counting && !any_src),
    .short_sel(short_delay), .done(cnt_done)
  );

  rst_cause_log u_cause (
    .clk(clk), .por_req(por_req), .src_pin(src_pin),
    .src_wdog(wdog_to), .src_addr(bad_addr), .cause(cause)
  );

  always_comb begin
    state_nx = state;
    if (any_src) state_nx = SEQ_HOLD;
    else begin
      unique case (state)
        SEQ_HOLD:     state_nx = SEQ_RST_CNT;
        SEQ_RST_CNT:  if (cnt_done) state_nx = SEQ_RUN;
        SEQ_RUN:      if (stop_req) state_nx = SEQ_STOP;
        SEQ_STOP:     if (wake)     state_nx = SEQ_WAKE_CNT;
        SEQ_WAKE_CNT: if (cnt_done) state_nx = SEQ_RUN;
        default:      state_nx = SEQ_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) state <= SEQ_HOLD;
    else         state <= state_nx;
  end

  assign core_rst  = (state == SEQ_HOLD) || (state == SEQ_RST_CNT);
  assign run_en    = (state == SEQ_RUN);
  assign rst_cause = cause;
endmodule

// File: rtl/rst_seq_chk.sv
`timescale 1ns/1ps
module rst_seq_chk
  import rst_seq_pkg::*;
(
  input logic       clk,
  input logic       por_req,
  input logic       wdog_to,
  input logic       bad_addr,
  input logic       stop_req,
  input logic       wake,
  input logic       src_pin,
  input seq_state_e state,
  input logic       core_rst,
  input logic       run_en
);
  logic quiet;
  assign quiet = !src_pin && !wdog_to && !bad_addr;

  always @(negedge clk) begin
    if (por_req) begin
      assert_por_hold_R1: assert (core_rst && !run_en);
    end
  end

  assert_never_both_R11: assert property (@(posedge clk) disable iff (por_req)
    !(core_rst && run_en));

  assert_sync_src_R3: assert property (@(posedge clk) disable iff (por_req)
    (wdog_to || bad_addr) |=> (core_rst && !run_en));

  assert_stop_entry_R8: assert property (@(posedge clk) disable iff (por_req)
    (state == SEQ_RUN && stop_req && quiet) |=> (!run_en && !core_rst));

  assert_wake_no_rst_R9: assert property (@(posedge clk) disable iff (por_req)
    (state == SEQ_STOP && wake && quiet) |=> (!core_rst && !run_en));
endmodule

bind rst_seq rst_seq_chk u_chk (
  .clk(clk), .por_req(por_req), .wdog_to(wdog_to), .bad_addr(bad_addr),
  .stop_req(stop_req), .wake(wake), .src_pin(src_pin), .state(state),
  .core_rst(core_rst), .run_en(run_en)
);

// File: tb/rst_seq_test.sv
`timescale 1ns/1ps
module rst_seq_test;
  localparam int LONG_N  = 4064;
  localparam int SHORT_N = 128;

  logic clk = 0;
  logic por_req = 1, ext_rst_n = 1, wdog_to = 0, bad_addr = 0;
  logic short_delay = 0, stop_req = 0, wake = 0;
  logic core_rst, run_en;
  logic [1:0] rst_cause;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rst_seq uut (
    .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n), .wdog_to(wdog_to),
    .bad_addr(bad_addr), .short_delay(short_delay), .stop_req(stop_req),
    .wake(wake), .core_rst(core_rst), .run_en(run_en), .rst_cause(rst_cause)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Also covers R11: the pair is checked at every expectation point.
  task automatic expect_out(input string req, input bit rst_e, input bit run_e);
    check(core_rst == rst_e, req, "core_rst", core_rst, rst_e);
    check(run_en == run_e, req, "run_en", run_en, run_e);
  endtask

  task automatic expect_cause(input string req, input logic [1:0] c);
    check(rst_cause == c, req, "rst_cause", rst_cause, c);
  endtask

  // Called at the negedge after edge A; run_en must rise at edge A+k.
  task automatic release_after(input int k, input bit pre_rst, input string req);
    repeat (k - 1) @(posedge clk);
    @(negedge clk);
    expect_out(req, pre_rst, 0);
    @(posedge clk);
    @(negedge clk);
    expect_out(req, 0, 1);
  endtask

  task automatic enter_stop(input string req);
    @(negedge clk) stop_req = 1;
    @(posedge clk);
    @(negedge clk) stop_req = 0;
    expect_out(req, 0, 0);
  endtask

  task automatic t_power_on;
    #1;
    expect_out("R1", 1, 0);
    expect_cause("R1", 2'b00);
    @(negedge clk) por_req = 0;
    release_after(LONG_N + 1, 1, "R6");
  endtask

  task automatic t_por_async;
    short_delay = 1;
    @(negedge clk);
    #1 por_req = 1;
    #0.5;
    expect_out("R1", 1, 0);
    expect_cause("R1", 2'b00);
    @(negedge clk) por_req = 0;
    release_after(SHORT_N + 1, 1, "R7");
  endtask

  task automatic t_watchdog;
    @(negedge clk) wdog_to = 1;
    @(posedge clk);
    @(negedge clk) wdog_to = 0;
    expect_out("R3", 1, 0);
    expect_cause("R3", 2'b10);
    release_after(SHORT_N + 1, 1, "R7");
  endtask

  task automatic t_bad_addr;
    @(negedge clk) bad_addr = 1;
    @(posedge clk);
    @(negedge clk) bad_addr = 0;
    expect_out("R3", 1, 0);
    expect_cause("R3", 2'b11);
    release_after(SHORT_N + 1, 1, "R3");
  endtask

  task automatic t_pin_glitch;
    @(negedge clk) ext_rst_n = 0;
    @(posedge clk);
    @(negedge clk) ext_rst_n = 1;
    repeat (6) @(negedge clk);
    expect_out("R2", 0, 1);
    expect_cause("R2", 2'b11);
  endtask

  task automatic t_pin_reset;
    @(negedge clk) ext_rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) ext_rst_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    expect_out("R2", 1, 0);
    expect_cause("R2", 2'b01);
    release_after(SHORT_N + 1, 1, "R2");
  endtask

  task automatic wait_run(input string req);
    bit seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (run_en) seen = 1;
    end
    check(seen, req, "run_en eventually", seen, 1);
  endtask

  task automatic t_priority;
    @(negedge clk) begin wdog_to = 1; bad_addr = 1; end
    @(posedge clk);
    @(negedge clk) begin wdog_to = 0; bad_addr = 0; end
    expect_cause("R4", 2'b10);
    release_after(SHORT_N + 1, 1, "R4");
    @(negedge clk) begin ext_rst_n = 0; wdog_to = 1; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    expect_cause("R4", 2'b01);
    ext_rst_n = 1; wdog_to = 0;
    wait_run("R4");
  endtask

  task automatic t_hold;
    @(negedge clk) wdog_to = 1;
    repeat (200) @(posedge clk);
    @(negedge clk);
    expect_out("R5", 1, 0);
    wdog_to = 0;
    release_after(SHORT_N + 1, 1, "R5");
  endtask

  task automatic t_stop_wake(input int n, input string req);
    enter_stop("R8");
    repeat (10) @(negedge clk);
    expect_out("R8", 0, 0);
    @(negedge clk) wake = 1;
    @(posedge clk);
    @(negedge clk) wake = 0;
    expect_out(req, 0, 0);
    release_after(n, 0, req);
  endtask

  task automatic t_src_in_stop;
    enter_stop("R10");
    @(negedge clk) bad_addr = 1;
    @(posedge clk);
    @(negedge clk) bad_addr = 0;
    expect_out("R10", 1, 0);
    expect_cause("R10", 2'b11);
    release_after(SHORT_N + 1, 1, "R10");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_power_on();
    t_por_async();
    t_watchdog();
    t_bad_addr();
    t_pin_glitch();
    t_pin_reset();
    t_priority();
    t_hold();
    t_stop_wake(SHORT_N, "R9");
    short_delay = 0;
    t_stop_wake(LONG_N, "R9");
    short_delay = 1;
    t_src_in_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule